// File: doc/BRIEF.md
# Flash Command Interface for a 32-bit Paired x16 Array

This block sits on a 32-bit memory-mapped data bus in front of a small on-chip flash array that is modelled as two 16-bit devices running in lockstep. Every command write therefore carries the same 16-bit code in both halves of the bus word. A cycle counter sequences the multi-write operations (block erase and buffered program), an 8-bit status byte records controller readiness and operation errors, and the read data path is steered by the current mode to the array, to the status byte or to the identifier.

The array contents are held in on-chip storage that comes out of reset as all ones. A buffered program data write clears bits in the addressed word (flash bits only go from one to zero). A block erase returns the whole addressed block to all ones. Program and erase complete at once, with no busy time. The bus address is a word address. Reads are combinational and reflect the mode in force at the time of the read.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80, the cycle counter is at the command cycle, `cmd_err` is 0, and every array word reads 0xFFFFFFFF.
- R2: In the command cycle, code 0x0070 selects status-read mode, 0x00FF selects array-read mode and 0x0090 selects identifier mode. Each of these completes in a single write. In identifier mode a read returns 0x00000000.
- R3: Code 0x0050 clears status bits 1, 3, 4 and 5, leaves the other status bits unchanged, and selects array-read mode.
- R4: Code 0x0020 is followed by one address write. If that word address is inside the array, the whole block holding it (BLOCK_BYTES/4 words, aligned) reads as all ones afterwards. If it is outside the array, status bit 5 is set and no word changes. In both cases the block then enters status-read mode and waits for a new command.
- R5: Code 0x00E8 is followed by a count write whose bits 15:0 give N. The next N writes are data writes, and each one ANDs its 32-bit data into the addressed word. A data write to a word address at or past the array sets status bit 4 and changes nothing.
- R6: Once the count has reached zero, a write whose bits 15:0 equal 0x00D0 returns the block to array-read mode at the command cycle. Any other value is ignored. From the setup write until the confirm, reads return the status byte.
- R7: In array-read mode, byte lane k (bits 8k+7:8k) of the read data is array byte 4*addr+k. Any byte at or beyond ARRAY_BYTES reads as 0xFF.
- R8: A command-cycle write is ignored and sets the sticky `cmd_err` when its two 16-bit halves differ or its code is not one of the seven listed. Mode and cycle counter are left unchanged, and `cmd_err` is cleared only by reset.
- R9: A status read returns the status byte in bits 7:0 and again in bits 23:16, with all other bits 0. Status bit 7 always reads 1, and bits 0, 2 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | $clog2(WINDOW_BYTES)-2 | Word address inside the mapped window |
| bus_wdata | input | 32 | Write data: command, count, address cycle or program data |
| bus_rdata | output | 32 | Read data for the current mode and address |
| cmd_err | output | 1 | Sticky flag for a rejected command write |

## Verification
The bench builds the block with ARRAY_BYTES = 62, BLOCK_BYTES = 16 and WINDOW_BYTES = 128. This gives a 16-word array in four 4-word blocks inside a 32-word window. Because the last word straddles the array end, lanes 2 and 3 of that word read as 0xFF while lanes 0 and 1 hold programmed data. Addresses past the array within the window are reachable, so both error bits can be raised. A small block size lets an erase be seen to stop at its block edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Command codes, compared on the low 16 bits with equal halves
    localparam logic [15:0] OP_ERASE_SETUP = 16'h0020;
    localparam logic [15:0] OP_CLR_STATUS  = 16'h0050;
    localparam logic [15:0] OP_RD_STATUS   = 16'h0070;
    localparam logic [15:0] OP_RD_IDENT    = 16'h0090;
    localparam logic [15:0] OP_PGM_SETUP   = 16'h00E8;
    localparam logic [15:0] OP_PGM_CONFIRM = 16'h00D0;
    localparam logic [15:0] OP_RD_ARRAY    = 16'h00FF;

    // Status byte positions that this block drives
    localparam int SB_PGM_ERR = 4;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_READY   = 7;

    localparam logic [7:0] STATUS_RESET    = 8'h80;
    localparam logic [7:0] STATUS_CLR_MASK = 8'h3A;  // bits 1,3,4,5

    typedef enum logic [2:0] {
        MODE_ARRAY,
        MODE_STATUS,
        MODE_IDENT,
        MODE_ERASE,
        MODE_PGM
    } mode_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ARRAY,
        CMD_STATUS,
        CMD_IDENT,
        CMD_CLEAR,
        CMD_ERASE,
        CMD_PGM
    } cmd_t;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ARG  = 2'd1,
        CYC_DATA = 2'd2
    } cyc_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [31:0] wdata,
    output cmd_t        cmd,
    output logic        confirm
);

    logic [15:0] lo_half;

    always_comb begin
        lo_half = wdata[15:0];
        cmd     = CMD_NONE;
        if (wdata[31:16] == lo_half) begin
            case (lo_half)
                OP_RD_ARRAY:    cmd = CMD_ARRAY;
                OP_RD_STATUS:   cmd = CMD_STATUS;
                OP_RD_IDENT:    cmd = CMD_IDENT;
                OP_CLR_STATUS:  cmd = CMD_CLEAR;
                OP_ERASE_SETUP: cmd = CMD_ERASE;
                OP_PGM_SETUP:   cmd = CMD_PGM;
                default:        cmd = CMD_NONE;
            endcase
        end
        // the confirm code is taken from the low half only
        confirm = (lo_half == OP_PGM_CONFIRM);
    end

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int WORDS       = 2048,
    parameter int BLOCK_WORDS = 1024,
    parameter int IDX_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_en,
    input  logic [IDX_W-1:0] pgm_idx,
    input  logic [31:0]      pgm_data,
    input  logic             ers_en,
    input  logic [IDX_W-1:0] ers_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    localparam int BLK_SHIFT = $clog2(BLOCK_WORDS);
    localparam int SEL_W     = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [31:0] mem_q [WORDS];
    logic [IDX_W-1:0] ers_blk;

    assign ers_blk = ers_idx >> BLK_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (ers_en && ((IDX_W'(i) >> BLK_SHIFT) == ers_blk)) begin
                    mem_q[i] <= '1;
                end else if (pgm_en && (pgm_idx == IDX_W'(i))) begin
                    mem_q[i] <= mem_q[i] & pgm_data;
                end
            end
        end
    end

    logic [SEL_W-1:0] rd_sel;
    logic             rd_inside;

    assign rd_sel    = rd_idx[SEL_W-1:0];
    assign rd_inside = ({1'b0, rd_idx} < (IDX_W+1)'(WORDS));
    assign rd_data   = rd_inside ? mem_q[rd_sel] : '1;

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_BYTES = 8192,
    parameter int AW          = 12
) (
    input  mode_t          mode,
    input  logic [7:0]     status,
    input  logic [AW-1:0]  addr,
    input  logic [31:0]    arr_word,
    output logic [31:0]    rdata
);

    localparam int BW = AW + 3;

    logic [31:0] arr_masked;

    // each byte lane is bounded against the array end on its own
    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [BW-1:0] byte_addr;
        assign byte_addr = {1'b0, addr, 2'(k)};
        assign arr_masked[8*k +: 8] =
            (byte_addr < BW'(ARRAY_BYTES)) ? arr_word[8*k +: 8] : 8'hFF;
    end

    always_comb begin
        case (mode)
            MODE_ARRAY: rdata = arr_masked;
            MODE_IDENT: rdata = '0;
            default:    rdata = {8'h00, status, 8'h00, status};
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_BYTES  = 8192,
    parameter int BLOCK_BYTES  = 4096,
    parameter int WINDOW_BYTES = 16384
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [$clog2(WINDOW_BYTES)-3:0]   bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              cmd_err
);

    localparam int AW          = $clog2(WINDOW_BYTES) - 2;
    localparam int ARRAY_WORDS = (ARRAY_BYTES + 3) / 4;
    localparam int BLOCK_WORDS = BLOCK_BYTES / 4;

    typedef struct packed {
        mode_t       mode;
        cyc_t        cyc;
        logic [15:0] cnt;
        logic [7:0]  status;
        logic        err;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    cmd_t        cmd;
    logic        confirm;
    logic        in_array;
    logic        pgm_en;
    logic        ers_en;
    logic [31:0] arr_word;

    flash_cmd_decode u_decode (
        .wdata   (bus_wdata),
        .cmd     (cmd),
        .confirm (confirm)
    );

    assign in_array = ({1'b0, bus_addr} < (AW+1)'(ARRAY_WORDS));

    always_comb begin
        ctl_d  = ctl_q;
        pgm_en = 1'b0;
        ers_en = 1'b0;
        if (bus_wr) begin
            case (ctl_q.cyc)
                CYC_CMD: begin
                    case (cmd)
                        CMD_ARRAY:  ctl_d.mode = MODE_ARRAY;
                        CMD_STATUS: ctl_d.mode = MODE_STATUS;
                        CMD_IDENT:  ctl_d.mode = MODE_IDENT;
                        CMD_CLEAR: begin
                            ctl_d.status = ctl_q.status & ~STATUS_CLR_MASK;
                            ctl_d.mode   = MODE_ARRAY;
                        end
                        CMD_ERASE: begin
                            ctl_d.mode = MODE_ERASE;
                            ctl_d.cyc  = CYC_ARG;
                        end
                        CMD_PGM: begin
                            ctl_d.mode = MODE_PGM;
                            ctl_d.cyc  = CYC_ARG;
                        end
                        default: ctl_d.err = 1'b1;
                    endcase
                end
                CYC_ARG: begin
                    if (ctl_q.mode == MODE_ERASE) begin
                        if (in_array) begin
                            ers_en = 1'b1;
                        end else begin
                            ctl_d.status[SB_ERS_ERR] = 1'b1;
                        end
                        ctl_d.mode = MODE_STATUS;
                        ctl_d.cyc  = CYC_CMD;
                    end else begin
                        ctl_d.cnt = bus_wdata[15:0];
                        ctl_d.cyc = CYC_DATA;
                    end
                end
                CYC_DATA: begin
                    if (ctl_q.cnt != 16'd0) begin
                        ctl_d.cnt = ctl_q.cnt - 16'd1;
                        if (in_array) begin
                            pgm_en = 1'b1;
                        end else begin
                            ctl_d.status[SB_PGM_ERR] = 1'b1;
                        end
                    end else if (confirm) begin
                        ctl_d.mode = MODE_ARRAY;
                        ctl_d.cyc  = CYC_CMD;
                    end
                end
                default: ctl_d.cyc = CYC_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_ARRAY, cyc: CYC_CMD, cnt: 16'd0,
                       status: STATUS_RESET, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_err = ctl_q.err;

    flash_array #(
        .WORDS       (ARRAY_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .IDX_W       (AW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (pgm_en),
        .pgm_idx  (bus_addr),
        .pgm_data (bus_wdata),
        .ers_en   (ers_en),
        .ers_idx  (bus_addr),
        .rd_idx   (bus_addr),
        .rd_data  (arr_word)
    );

    flash_rd_mux #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .AW          (AW)
    ) u_rd_mux (
        .mode     (ctl_q.mode),
        .status   (ctl_q.status),
        .addr     (bus_addr),
        .arr_word (arr_word),
        .rdata    (bus_rdata)
    );

    // R1: one cycle after reset is seen, the control state is at its reset values
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q.mode == MODE_ARRAY && ctl_q.cyc == CYC_CMD &&
                    ctl_q.status == STATUS_RESET && !cmd_err));

    // R9: the controller-ready bit never drops and unused bits stay low
    p_ready_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.status[SB_READY] && !ctl_q.status[0] &&
        !ctl_q.status[2] && !ctl_q.status[6]);

    // R8: a rejected command leaves mode and cycle alone and raises the flag
    p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl_q.cyc == CYC_CMD && cmd == CMD_NONE)
        |=> ($stable(ctl_q.mode) && $stable(ctl_q.cyc) && cmd_err));

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R3: clear status drops the four error bits and returns to array read
    p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl_q.cyc == CYC_CMD && cmd == CMD_CLEAR)
        |=> (ctl_q.status[1] == 1'b0 && ctl_q.status[3] == 1'b0 &&
             ctl_q.status[4] == 1'b0 && ctl_q.status[5] == 1'b0 &&
             ctl_q.mode == MODE_ARRAY));

    // R4: the erase address write ends in status mode at the command cycle
    p_erase_to_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl_q.cyc == CYC_ARG && ctl_q.mode == MODE_ERASE)
        |=> (ctl_q.mode == MODE_STATUS && ctl_q.cyc == CYC_CMD));

    // R5: each data write with a nonzero count takes exactly one off the count
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl_q.cyc == CYC_DATA && ctl_q.cnt != 16'd0)
        |=> (ctl_q.cnt == $past(ctl_q.cnt) - 16'd1 && ctl_q.cyc == CYC_DATA));

    // R6: a confirm at zero count ends the program in array-read mode
    p_confirm_to_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl_q.cyc == CYC_DATA && ctl_q.cnt == 16'd0 && confirm)
        |=> (ctl_q.mode == MODE_ARRAY && ctl_q.cyc == CYC_CMD));

    // the cycle counter never takes its unused encoding
    p_cycle_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cyc != 2'd3);

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P_ARRAY    = 62;
    localparam int P_BLOCK    = 16;
    localparam int P_WINDOW   = 128;
    localparam int AW         = $clog2(P_WINDOW) - 2;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic          rd;
        logic [3:0]    req;
        logic [AW-1:0] addr;
        logic [31:0]   data;
    } vec_t;

    localparam logic W = 1'b0;
    localparam logic R = 1'b1;
    localparam int NVEC = 40;

    // writes apply data; reads compare bus_rdata with data
    localparam vec_t VEC [NVEC] = '{
        '{R, 4'd7, 5'd0,  32'hFFFF_FFFF},  // R7 fresh array
        '{R, 4'd7, 5'd20, 32'hFFFF_FFFF},  // R7 past array end
        '{W, 4'd5, 5'd0,  32'h00E8_00E8},  // R5 program setup
        '{R, 4'd6, 5'd0,  32'h0080_0080},  // R6 status while programming
        '{W, 4'd5, 5'd0,  32'h0000_0002},  // R5 count 2
        '{W, 4'd5, 5'd3,  32'h1234_5678},
        '{W, 4'd5, 5'd15, 32'h0000_0000},
        '{R, 4'd6, 5'd9,  32'h0080_0080},  // R6 still status at count 0
        '{W, 4'd6, 5'd0,  32'h00D0_00D0},  // R6 confirm
        '{R, 4'd5, 5'd3,  32'h1234_5678},  // R5 programmed word
        '{R, 4'd7, 5'd15, 32'hFFFF_0000},  // R7 lanes 2,3 past end
        '{R, 4'd7, 5'd16, 32'hFFFF_FFFF},
        '{W, 4'd2, 5'd0,  32'h0090_0090},  // R2 identifier
        '{R, 4'd2, 5'd3,  32'h0000_0000},
        '{W, 4'd2, 5'd0,  32'h0070_0070},  // R2 status read
        '{R, 4'd2, 5'd3,  32'h0080_0080},
        '{W, 4'd4, 5'd0,  32'h0020_0020},  // R4 erase setup
        '{W, 4'd4, 5'd2,  32'h0000_0000},  // R4 erase block 0
        '{R, 4'd4, 5'd0,  32'h0080_0080},  // R4 now in status mode
        '{W, 4'd4, 5'd0,  32'h00FF_00FF},
        '{R, 4'd4, 5'd3,  32'hFFFF_FFFF},  // R4 word 3 erased
        '{R, 4'd4, 5'd15, 32'hFFFF_0000},  // R4 block 3 untouched
        '{W, 4'd4, 5'd0,  32'h0020_0020},
        '{W, 4'd4, 5'd20, 32'h0000_0000},  // R4 address past array
        '{R, 4'd4, 5'd0,  32'h00A0_00A0},  // R4 erase error bit 5
        '{W, 4'd5, 5'd0,  32'h00E8_00E8},
        '{W, 4'd5, 5'd0,  32'h0000_0003},
        '{W, 4'd5, 5'd4,  32'hF0F0_F0F0},
        '{W, 4'd5, 5'd4,  32'hFF00_FF00},  // R5 AND into same word
        '{W, 4'd5, 5'd16, 32'h0000_0000},  // R5 data past array
        '{R, 4'd5, 5'd0,  32'h00B0_00B0},  // R5 program error bit 4
        '{W, 4'd6, 5'd0,  32'h0000_1234},  // R6 not a confirm
        '{R, 4'd6, 5'd0,  32'h00B0_00B0},  // R6 still programming
        '{W, 4'd6, 5'd0,  32'h0000_00D0},  // R6 confirm from low half
        '{R, 4'd5, 5'd4,  32'hF000_F000},
        '{R, 4'd5, 5'd16, 32'hFFFF_FFFF},
        '{W, 4'd3, 5'd0,  32'h0050_0050},  // R3 clear status
        '{R, 4'd3, 5'd4,  32'hF000_F000},  // R3 back in array mode
        '{W, 4'd3, 5'd0,  32'h0070_0070},
        '{R, 4'd9, 5'd0,  32'h0080_0080}   // R9 and R3 bits cleared
    };

    logic          clk;
    logic          rst_n;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          cmd_err;

    int n_chk;
    int n_err;

    flash_cmd_ctrl #(
        .ARRAY_BYTES  (P_ARRAY),
        .BLOCK_BYTES  (P_BLOCK),
        .WINDOW_BYTES (P_WINDOW)
    ) u_flash_cmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmd_err   (cmd_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] dat);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = dat;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        n_chk     = 0;
        n_err     = 0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        do_reset();

        // R1 reset state at the ports
        @(negedge clk); #1;
        chk("R1 cmd_err after reset", {31'd0, cmd_err}, 32'd0);
        do_rd("R1 array after reset", 5'd7, 32'hFFFF_FFFF);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                do_rd($sformatf("R%0d vector %0d", VEC[i].req, i),
                      VEC[i].addr, VEC[i].data);
            end else begin
                do_wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R8 no error flag from valid traffic
        @(negedge clk); #1;
        chk("R8 no flag after valid commands", {31'd0, cmd_err}, 32'd0);

        // R8 halves differ: ignored, flag set, still in status mode
        do_wr(5'd0, 32'h00FF_0070);
        @(negedge clk); #1;
        chk("R8 flag on mismatched halves", {31'd0, cmd_err}, 32'd1);
        do_rd("R8 mode kept after mismatch", 5'd4, 32'h0080_0080);

        // R8 flag sticky through a valid command
        do_wr(5'd0, 32'h00FF_00FF);
        @(negedge clk); #1;
        chk("R8 flag sticky", {31'd0, cmd_err}, 32'd1);
        do_rd("R2 array mode selected", 5'd4, 32'hF000_F000);

        // R8 unknown code leaves array mode in place
        do_wr(5'd0, 32'h0033_0033);
        do_rd("R8 mode kept after unknown code", 5'd4, 32'hF000_F000);

        // R6 zero count: confirm accepted at once
        do_wr(5'd0, 32'h00E8_00E8);
        do_wr(5'd0, 32'h0000_0000);
        do_wr(5'd0, 32'h00D0_00D0);
        do_rd("R6 zero count confirm", 5'd4, 32'hF000_F000);

        // R1 reset in the middle of a program sequence
        do_wr(5'd0, 32'h00E8_00E8);
        do_wr(5'd0, 32'h0000_0004);
        do_reset();
        @(negedge clk); #1;
        chk("R1 flag cleared by reset", {31'd0, cmd_err}, 32'd0);
        do_rd("R1 array back to ones", 5'd4, 32'hFFFF_FFFF);
        do_wr(5'd0, 32'h0070_0070);
        do_rd("R1 status 0x80 after reset", 5'd0, 32'h0080_0080);

        finish_run();
    end

endmodule